// File: doc/BRIEF.md
# Interleaved I/Q Tone Mixer

The block takes one stream of signed samples in which even and odd positions alternate between the in-phase and the quadrature rail. It turns each sample into a complex value by putting the sample on its own rail and a zero on the other. It then moves the whole spectrum in frequency by a complex multiply with a tone from a numerically controlled oscillator.

The oscillator keeps a 32-bit phase that advances by a programmable step for every accepted sample. The top bits of that phase address a sine table that holds one full cycle. The cosine is read from the same table a quarter turn further on. Only one quarter of the wave is stored, and the other three quarters are rebuilt by symmetry. Each product is cut back to 16 bits by an arithmetic right shift of 15, with no rounding. There is one output for every input, after a fixed pipeline delay.

Top module: `iq_tone_mixer`

## Requirements
- R1: A sample at an even stream position (position 0, 2, 4, ...) enters the mixer as the complex value (x, 0): x on the in-phase rail, zero on the quadrature rail.
- R2: A sample at an odd stream position enters the mixer as (0, x). Positions count accepted samples only, so idle cycles between samples do not change the parity.
- R3: While rst_n is low at a rising edge, the phase, the parity and the step register all clear to zero, and out_valid, out_i and out_q are zero. The first sample after reset is even and uses phase 0.
- R4: Each accepted sample uses the current phase. After that sample, the phase advances by the step register modulo 2^32.
- R5: The table index is the phase shifted right by 21, which gives 11 bits and 2048 positions over one turn.
- R6: The table entry at index k is sin(2*pi*k/2048)*32767 truncated toward zero. Its magnitude is never more than 32767.
- R7: The in-phase rotation term ri is the entry at (k+512) mod 2048. The quadrature term rq is the negated entry at k.
- R8: out_i is bits [30:15] of (i*ri - q*rq), and out_q is bits [30:15] of (q*ri + i*rq). These are the 16 low bits of the exact sum after an arithmetic shift right by 15.
- R9: out_valid is high for exactly one cycle, three rising edges after each cycle where in_valid is high, and is low otherwise. The outputs come out in input order.
- R10: A pulse on freq_wr loads freq_word into the step register. The new step is used for every sample accepted after that edge. Loading does not change the phase.
- R11: All 32 phase bits accumulate. For example, a step of 2^20 moves the table index by one every second sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input sample strobe |
| in_sample | input | 16 | Signed interleaved I/Q sample |
| freq_wr | input | 1 | Load strobe for the step register |
| freq_word | input | 32 | Phase step per sample (2^32 = one turn) |
| out_valid | output | 1 | Output strobe |
| out_i | output | 16 | Shifted in-phase result, signed |
| out_q | output | 16 | Shifted quadrature result, signed |

## Verification
The bound checker checks the following on every cycle:
- the three-cycle valid latency;
- that an even sample arrives with a zero quadrature rail and its own value on the in-phase rail;
- that the phase moves by the step exactly when a sample is taken and holds otherwise;
- that the rotation pair stays inside full scale and close to the unit circle;
- that a zero input gives a zero output.

The bench scenarios cover the things only a reference model can show:
- the exact rotated values at quarter-turn, fine and arbitrary steps;
- 32-bit phase wrap;
- a step change in mid-stream that keeps phase continuity;
- a mid-stream reset that restores the even parity and phase 0;
- the truncation at full-scale negative inputs.

// File: rtl/iqmix_pkg.sv
// Shared widths and types for the interleaved I/Q tone mixer.
// Assumes: two's-complement samples, unsigned phase modulo 2^PH_W.
package iqmix_pkg;
    localparam int SMP_W  = 16;          // sample and output width
    localparam int PH_W   = 32;          // phase accumulator width
    localparam int IDX_W  = 11;          // table index width
    localparam int FRAC_W = 15;          // fraction bits of table entries
    localparam int AMP    = (1 << FRAC_W) - 1;

    typedef logic signed [SMP_W-1:0] smp_t;
    typedef logic [PH_W-1:0]         phase_t;
endpackage

// File: rtl/iq_splitter.sv
// Splits an interleaved stream into complex samples with zero fill.
// Even positions go to the in-phase rail and odd positions to the quadrature rail.
// Assumes: the parity advances only on accepted samples.
module iq_splitter #(
    parameter int W = iqmix_pkg::SMP_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic signed [W-1:0] in_sample,
    output logic                sp_valid,
    output logic signed [W-1:0] sp_i,
    output logic signed [W-1:0] sp_q
);
    logic odd_pos;

    // Tracks which rail the next accepted sample belongs to.
    always_ff @(posedge clk) begin
        if (!rst_n)
            odd_pos <= 1'b0;
        else if (in_valid)
            odd_pos <= ~odd_pos;
    end

    // Registers the complex sample, putting a zero on the rail that is not used.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp_valid <= 1'b0;
            sp_i     <= '0;
            sp_q     <= '0;
        end else begin
            sp_valid <= in_valid;
            if (in_valid) begin
                sp_i <= odd_pos ? '0 : in_sample;
                sp_q <= odd_pos ? in_sample : '0;
            end
        end
    end
endmodule

// File: rtl/nco_phase.sv
// Phase accumulator with a loadable step register.
// Emits the table index of the phase that each accepted sample uses, and then advances.
// Assumes: a step load and a sample in the same cycle give that sample the old step.
module nco_phase #(
    parameter int PH_W  = iqmix_pkg::PH_W,
    parameter int IDX_W = iqmix_pkg::IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             freq_wr,
    input  logic [PH_W-1:0]  freq_word,
    input  logic             step,
    output logic [IDX_W-1:0] ph_idx,
    output logic [PH_W-1:0]  phase_acc,
    output logic [PH_W-1:0]  freq_q
);
    localparam int SHIFT = PH_W - IDX_W;

    // Holds the programmed step.
    always_ff @(posedge clk) begin
        if (!rst_n)
            freq_q <= '0;
        else if (freq_wr)
            freq_q <= freq_word;
    end

    // Captures the index for the current sample and advances the full-width phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_acc <= '0;
            ph_idx    <= '0;
        end else if (step) begin
            ph_idx    <= phase_acc[SHIFT +: IDX_W];
            phase_acc <= phase_acc + freq_q;
        end
    end
endmodule

// File: rtl/quarter_sine_lut.sv
// Full-cycle sine lookup built from a quarter-wave table.
// The table is computed at elaboration. Entries are truncated toward zero.
// Assumes: IDX_W >= 3. The output magnitude is at most 2^FRAC_W - 1.
module quarter_sine_lut #(
    parameter int IDX_W  = iqmix_pkg::IDX_W,
    parameter int AMP_W  = iqmix_pkg::SMP_W,
    parameter int FRAC_W = iqmix_pkg::FRAC_W
) (
    input  logic [IDX_W-1:0]        idx,
    output logic signed [AMP_W-1:0] value
);
    localparam int  QN    = 1 << (IDX_W - 2);
    localparam int  OFF_W = IDX_W - 2;
    localparam int  ADR_W = IDX_W - 1;
    localparam real SCALE = real'((1 << FRAC_W) - 1);
    localparam real TWO_PI = 6.283185307179586;

    typedef logic signed [AMP_W-1:0] qtab_t [0:QN];

    function automatic qtab_t build_qtab();
        qtab_t t;
        for (int k = 0; k <= QN; k++)
            t[k] = AMP_W'($rtoi($sin(TWO_PI * real'(k) / real'(4 * QN)) * SCALE));
        return t;
    endfunction

    localparam qtab_t QTAB = build_qtab();

    logic [1:0]              quad;
    logic [OFF_W-1:0]        off;
    logic [ADR_W-1:0]        addr;
    logic signed [AMP_W-1:0] mag;

    // Folds the index onto the first quadrant and restores the sign.
    always_comb begin
        quad  = idx[IDX_W-1 -: 2];
        off   = idx[OFF_W-1:0];
        addr  = quad[0] ? ADR_W'(QN) - ADR_W'(off) : ADR_W'(off);
        mag   = QTAB[addr];
        value = quad[1] ? -mag : mag;
    end
endmodule

// File: rtl/cmplx_rotator.sv
// Two-stage complex multiply by the oscillator tone.
// Stage one registers the rotation pair and the sample. Stage two multiplies,
// shifts right by FRAC_W and keeps the low W bits.
// Assumes: rotation magnitudes of at most 2^FRAC_W - 1.
module cmplx_rotator #(
    parameter int W      = iqmix_pkg::SMP_W,
    parameter int FRAC_W = iqmix_pkg::FRAC_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_vld,
    input  logic signed [W-1:0] a_i,
    input  logic signed [W-1:0] a_q,
    input  logic signed [W-1:0] cos_v,
    input  logic signed [W-1:0] sin_v,
    output logic                rot_vld,
    output logic signed [W-1:0] rot_i,
    output logic signed [W-1:0] rot_q,
    output logic signed [W-1:0] d_i,
    output logic signed [W-1:0] d_q,
    output logic                y_vld,
    output logic signed [W-1:0] y_i,
    output logic signed [W-1:0] y_q
);
    localparam int PROD_W = 2 * W;
    localparam int SUM_W  = PROD_W + 1;

    logic signed [PROD_W-1:0] p_ii, p_qq, p_qi, p_iq;
    logic signed [SUM_W-1:0]  s_i, s_q;

    // Registers the rotation pair (cosine, negated sine) with the data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rot_vld <= 1'b0;
            rot_i   <= '0;
            rot_q   <= '0;
            d_i     <= '0;
            d_q     <= '0;
        end else begin
            rot_vld <= in_vld;
            if (in_vld) begin
                rot_i <= cos_v;
                rot_q <= -sin_v;
                d_i   <= a_i;
                d_q   <= a_q;
            end
        end
    end

    // Forms the four products and the two exact sums.
    always_comb begin
        p_ii = d_i * rot_i;
        p_qq = d_q * rot_q;
        p_qi = d_q * rot_i;
        p_iq = d_i * rot_q;
        s_i  = SUM_W'(p_ii) - SUM_W'(p_qq);
        s_q  = SUM_W'(p_qi) + SUM_W'(p_iq);
    end

    // Registers the truncated results.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            y_vld <= 1'b0;
            y_i   <= '0;
            y_q   <= '0;
        end else begin
            y_vld <= rot_vld;
            if (rot_vld) begin
                y_i <= s_i[FRAC_W +: W];
                y_q <= s_q[FRAC_W +: W];
            end
        end
    end
endmodule

// File: rtl/iq_tone_mixer.sv
// Top level: interleaved I/Q input, oscillator and complex rotation.
// Latency is three edges from in_valid to out_valid, with one output per input.
// Assumes: a synchronous, active-low reset.
module iq_tone_mixer #(
    parameter int W      = iqmix_pkg::SMP_W,
    parameter int PH_W   = iqmix_pkg::PH_W,
    parameter int IDX_W  = iqmix_pkg::IDX_W,
    parameter int FRAC_W = iqmix_pkg::FRAC_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic signed [W-1:0] in_sample,
    input  logic                freq_wr,
    input  logic [PH_W-1:0]     freq_word,
    output logic                out_valid,
    output logic signed [W-1:0] out_i,
    output logic signed [W-1:0] out_q
);
    localparam int QUARTER = 1 << (IDX_W - 2);

    logic                sp_valid;
    logic signed [W-1:0] sp_i, sp_q;
    logic [IDX_W-1:0]    ph_idx;
    logic [PH_W-1:0]     phase_acc, freq_q;
    logic signed [W-1:0] lut_v [2];
    logic                rot_vld;
    logic signed [W-1:0] rot_i, rot_q, d_i, d_q;

    iq_splitter #(.W(W)) u_split (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
        .sp_valid(sp_valid), .sp_i(sp_i), .sp_q(sp_q)
    );

    nco_phase #(.PH_W(PH_W), .IDX_W(IDX_W)) u_phase (
        .clk(clk), .rst_n(rst_n), .freq_wr(freq_wr), .freq_word(freq_word),
        .step(in_valid), .ph_idx(ph_idx), .phase_acc(phase_acc), .freq_q(freq_q)
    );

    // Lookup 0 gives the cosine (a quarter turn ahead), lookup 1 gives the sine.
    for (genvar g = 0; g < 2; g++) begin : g_lut
        localparam logic [IDX_W-1:0] OFS = (g == 0) ? IDX_W'(QUARTER) : '0;
        quarter_sine_lut #(.IDX_W(IDX_W), .AMP_W(W), .FRAC_W(FRAC_W)) u_lut (
            .idx(ph_idx + OFS), .value(lut_v[g])
        );
    end

    cmplx_rotator #(.W(W), .FRAC_W(FRAC_W)) u_rot (
        .clk(clk), .rst_n(rst_n), .in_vld(sp_valid), .a_i(sp_i), .a_q(sp_q),
        .cos_v(lut_v[0]), .sin_v(lut_v[1]),
        .rot_vld(rot_vld), .rot_i(rot_i), .rot_q(rot_q), .d_i(d_i), .d_q(d_q),
        .y_vld(out_valid), .y_i(out_i), .y_q(out_q)
    );
endmodule

// File: rtl/iq_tone_mixer_chk.sv
// Checker for iq_tone_mixer. It is attached with the bind statement at the end of this file.
module iq_tone_mixer_chk #(
    parameter int W    = iqmix_pkg::SMP_W,
    parameter int PH_W = iqmix_pkg::PH_W
) (
    input logic                clk,
    input logic                rst_n,
    input logic                in_valid,
    input logic signed [W-1:0] in_sample,
    input logic                sp_valid,
    input logic signed [W-1:0] sp_i,
    input logic signed [W-1:0] sp_q,
    input logic [PH_W-1:0]     phase_acc,
    input logic [PH_W-1:0]     freq_q,
    input logic                rot_vld,
    input logic signed [W-1:0] rot_i,
    input logic signed [W-1:0] rot_q,
    input logic signed [W-1:0] d_i,
    input logic signed [W-1:0] d_q,
    input logic                out_valid,
    input logic signed [W-1:0] out_i,
    input logic signed [W-1:0] out_q
);
    localparam longint FULL = 64'd32767 * 64'd32767;
    logic [1:0] since_rst;
    logic       chk_odd;
    longint     r2;

    // Counts the edges since reset, saturating at 3.
    always_ff @(posedge clk) begin
        if (!rst_n)
            since_rst <= '0;
        else if (since_rst != 2'd3)
            since_rst <= since_rst + 2'd1;
    end

    // Keeps an independent count of sample parity.
    always_ff @(posedge clk) begin
        if (!rst_n)
            chk_odd <= 1'b0;
        else if (in_valid)
            chk_odd <= ~chk_odd;
    end

    // Squared radius of the rotation pair.
    always_comb r2 = longint'(rot_i) * longint'(rot_i) + longint'(rot_q) * longint'(rot_q);

    p_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd3) |-> (out_valid == $past(in_valid, 3)));

    p_even_fill_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !chk_odd) |=> (sp_valid && sp_q == '0 && sp_i == $past(in_sample)));

    p_odd_fill_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && chk_odd) |=> (sp_valid && sp_i == '0 && sp_q == $past(in_sample)));

    p_phase_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (phase_acc == $past(phase_acc) + $past(freq_q)));

    p_phase_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(phase_acc));

    p_rot_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rot_vld |-> (rot_i != 16'sh8000 && rot_q != 16'sh8000));

    p_unit_circle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rot_vld |-> (r2 <= FULL && r2 >= FULL - 64'd131072));

    p_zero_in_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rot_vld && d_i == '0 && d_q == '0) |=> (out_i == '0 && out_q == '0));
endmodule

bind iq_tone_mixer iq_tone_mixer_chk #(.W(W), .PH_W(PH_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
    .sp_valid(sp_valid), .sp_i(sp_i), .sp_q(sp_q),
    .phase_acc(phase_acc), .freq_q(freq_q),
    .rot_vld(rot_vld), .rot_i(rot_i), .rot_q(rot_q), .d_i(d_i), .d_q(d_q),
    .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
);

// File: tb/sim_iq_tone_mixer.sv
`timescale 1ns/1ps
module sim_iq_tone_mixer;
    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               in_valid = 1'b0;
    logic signed [15:0] in_sample = '0;
    logic               freq_wr = 1'b0;
    logic [31:0]        freq_word = '0;
    logic               out_valid;
    logic signed [15:0] out_i, out_q;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // Reference model state
    logic [31:0] m_phase, m_freq;
    bit          m_odd;
    logic [31:0] lcg = 32'h1234_5678;

    shortint exp_i [0:255];
    shortint exp_q [0:255];
    shortint got_i [0:255];
    shortint got_q [0:255];
    int en = 0;
    int gn = 0;

    iq_tone_mixer u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
        .freq_wr(freq_wr), .freq_word(freq_word),
        .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
    );

    always #2.5 clk = ~clk;

    // Collects every output away from the active edge.
    always @(negedge clk) begin
        if (rst_n && out_valid && gn < 256) begin
            got_i[gn] = out_i;
            got_q[gn] = out_q;
            gn++;
        end
    end

    function automatic int tbl(int k);
        real v;
        v = $sin(2.0 * 3.141592653589793 * real'(k) / 2048.0) * 32767.0;
        return $rtoi(v);
    endfunction

    task automatic check(input string req, input longint act, input longint expv, input string what);
        checks++;
        if (act != expv) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        in_valid = 1'b0;
        freq_wr = 1'b0;
        repeat (3) @(negedge clk);
        check("R3", out_valid, 0, "out_valid in reset");
        check("R3", out_i, 0, "out_i in reset");
        check("R3", out_q, 0, "out_q in reset");
        rst_n = 1'b1;
        m_phase = '0; m_freq = '0; m_odd = 1'b0;
        en = 0; gn = 0;
    endtask

    task automatic set_freq(input logic [31:0] f);
        @(negedge clk);
        freq_wr = 1'b1;
        freq_word = f;
        @(negedge clk);
        freq_wr = 1'b0;
        m_freq = f;
    endtask

    // Drives one sample, adds the expected result, then leaves gap idle cycles.
    task automatic send(input shortint x, input int gap);
        longint i, q, ri, rq, si, sq;
        int k;
        @(negedge clk);
        in_valid = 1'b1;
        in_sample = x;
        k = int'(m_phase >> 21);
        i = m_odd ? 0 : longint'(x);
        q = m_odd ? longint'(x) : 0;
        ri = tbl((k + 512) % 2048);
        rq = -tbl(k);
        si = (i * ri - q * rq) >>> 15;
        sq = (q * ri + i * rq) >>> 15;
        exp_i[en] = shortint'(si);
        exp_q[en] = shortint'(sq);
        en++;
        m_phase = m_phase + m_freq;
        m_odd = ~m_odd;
        @(negedge clk);
        in_valid = 1'b0;
        repeat (gap) @(negedge clk);
    endtask

    task automatic drain(input string req);
        repeat (6) @(negedge clk);
        check("R9", gn, en, {"output count for ", req});
        for (int n = 0; n < en && n < gn; n++) begin
            check(req, got_i[n], exp_i[n], $sformatf("out_i #%0d", n));
            check(req, got_q[n], exp_q[n], $sformatf("out_q #%0d", n));
        end
        en = 0; gn = 0;
    endtask

    // R1 R2 R3: zero step, so the rotation is the identity and the fill pattern shows.
    task automatic t_fill();
        do_reset();
        send(16'sd1000, 0);
        send(-16'sd1000, 0);
        send(16'sd20000, 2);
        send(-16'sd7, 0);
        drain("R1 R2");
    endtask

    // R5 R7: quarter-turn step through all four quadrants.
    task automatic t_quarter();
        do_reset();
        set_freq(32'h4000_0000);
        for (int n = 0; n < 8; n++) send(shortint'(3000 + 1000 * n), 0);
        drain("R5 R7");
    endtask

    // R4 R6 R8: arbitrary step with pseudo-random samples.
    task automatic t_sweep();
        do_reset();
        set_freq(32'h0371_5A3D);
        for (int n = 0; n < 40; n++) begin
            lcg = lcg * 32'd1664525 + 32'd1013904223;
            send(shortint'(lcg[31:16]), n % 3);
        end
        drain("R4 R6 R8");
    endtask

    // R11: a fine step only moves the index every second sample.
    task automatic t_fine();
        do_reset();
        set_freq(32'h0010_0000);
        for (int n = 0; n < 24; n++) send(16'sd30000, 0);
        drain("R11");
    endtask

    // R10: change the step in mid-stream, with no phase reset.
    task automatic t_retune();
        do_reset();
        set_freq(32'h1000_0000);
        for (int n = 0; n < 5; n++) send(16'sd12345, 0);
        set_freq(32'hE800_0000);
        for (int n = 0; n < 6; n++) send(-16'sd12345, 1);
        drain("R10");
    endtask

    // R4: a step near 2^32 wraps the phase.
    task automatic t_wrap();
        do_reset();
        set_freq(32'hFFE0_0000);
        for (int n = 0; n < 10; n++) send(16'sd25000, 0);
        drain("R4");
    endtask

    // R8: full-scale negative inputs show the truncation.
    task automatic t_extreme();
        do_reset();
        send(-16'sd32768, 0);
        send(-16'sd32768, 0);
        send(16'sd32767, 0);
        send(16'sd1, 0);
        send(-16'sd1, 0);
        drain("R8");
    endtask

    // R9: exact latency of a single sample, with the gaps around it.
    task automatic t_latency();
        do_reset();
        @(negedge clk);
        in_valid = 1'b1;
        in_sample = 16'sd500;
        exp_i[en] = shortint'((longint'(500) * 32767) >>> 15);
        exp_q[en] = 0;
        en++;
        m_phase = m_phase + m_freq; m_odd = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check("R9", out_valid, 0, "valid after 1 edge");
        @(negedge clk);
        check("R9", out_valid, 0, "valid after 2 edges");
        @(negedge clk);
        check("R9", out_valid, 1, "valid after 3 edges");
        @(negedge clk);
        check("R9", out_valid, 0, "valid after 4 edges");
        drain("R9");
    endtask

    // R3: a reset in mid-stream restores even parity and phase 0.
    task automatic t_midreset();
        do_reset();
        set_freq(32'h2345_6789);
        send(16'sd4000, 0);
        send(16'sd4000, 0);
        send(16'sd4000, 0);
        drain("R3");
        do_reset();
        send(16'sd4000, 0);
        drain("R3");
    endtask

    initial begin
        t_latency();
        t_fill();
        t_quarter();
        t_sweep();
        t_fine();
        t_retune();
        t_wrap();
        t_extreme();
        t_midreset();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule